// File: doc/BRIEF.md
# Permission-Tagged Crypto Register File

This block holds eight wide secret registers for a crypto unit. Each register carries a 5-bit permission tag that says whether it may be read, written or handed to a cipher as a key. The checks depend on the current privilege mode. Commands arrive one per cycle on a simple command interface. They can load a value, copy one register into another, XOR two registers, fill a register from an external random source, or rewrite a register's tag. Whenever a command moves data, the tag travels with the data, so a copy of a protected value stays protected.

The block has two independent request ports. One returns register contents for reading. The other releases a register's contents to the cipher as a key. A request that the tag does not allow returns nothing and raises a one-cycle fault pulse. A command that the tag does not allow raises the same pulse and changes nothing.

Top module: `crypto_regfile`

## Requirements
- R1: After reset every register holds zero and every tag is 5'b11111. `rd_valid`, `key_valid`, `fault`, `rd_data` and `key_data` are all zero.
- R2: Tag bit positions are: bit 0 allows key use in the lower modes, bit 1 allows key use in the high mode, bit 2 allows reads in the lower modes, bit 3 allows reads in the high mode, and bit 4 allows writes in the lower modes. `mode` 2 is the high mode. Values 0, 1 and 3 are all lower modes.
- R3: A read request with `rd_req`=1 and index `rd_idx` is answered one cycle later. If the tag allows it, `rd_valid`=1 and `rd_data` carries the register value. If not, `rd_valid`=0, `rd_data`=0 and `fault`=1.
- R4: A key request with `key_req`=1 and index `key_idx` is answered one cycle later in the same way on `key_valid`/`key_data`, using the key bits of the tag.
- R5: Command code 1 (load) writes `cmd_wdata` into the destination register and leaves its tag unchanged.
- R6: Command code 2 (move) copies both the data and the tag of source A into the destination.
- R7: Command code 3 (xor) writes A xor B into the destination, and its tag becomes the bitwise AND of both source tags. An xor of a register with itself clears it.
- R8: Command code 4 (random fill) writes `rnd_data` into the destination and leaves its tag unchanged.
- R9: Command code 5 (change permission) writes `cmd_imm` into the destination tag and leaves the data unchanged.
- R10: Codes 1 to 5 need write permission on the destination. This permission is always granted in the high mode and comes from bit 4 in the lower modes. A denied command pulses `fault` one cycle later and changes neither data nor tag. Codes 0, 6 and 7 do nothing and never fault.
- R11: A read or key request in the same cycle as a command sees the register state from before that command. The command's effect is visible from the next cycle on.
- R12: `fault` is high for exactly the cycle after a cycle with at least one denied access, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Privilege mode, 2 = high mode |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_dst | input | 3 | Destination register index |
| cmd_src_a | input | 3 | First source register index |
| cmd_src_b | input | 3 | Second source register index |
| cmd_imm | input | 5 | New tag for the change-permission command |
| cmd_wdata | input | 128 | Data for the load command |
| rnd_data | input | 128 | Random data for the fill command |
| rd_req | input | 1 | Read request |
| rd_idx | input | 3 | Read register index |
| rd_valid | output | 1 | Granted read data present |
| rd_data | output | 128 | Read data, zero unless granted |
| key_req | input | 1 | Key-use request |
| key_idx | input | 3 | Key register index |
| key_valid | output | 1 | Granted key present |
| key_data | output | 128 | Key data, zero unless granted |
| fault | output | 1 | One-cycle pulse after a denied access |

## Verification
A corrupted data word shows up on `rd_data` or `key_data` in the cycle after the next granted request to that register. A corrupted tag shows up as a wrong `rd_valid`, `key_valid` or `fault` in the cycle after the next request or lower-mode command that consults the bit that went wrong. A tag that propagates wrongly on a move or xor stays hidden until the destination is accessed in a mode that tests the affected bit. For that reason the stimulus mixes read and key requests in every mode with commands on nearly every cycle, so a wrong state is usually seen within a few cycles.

// File: rtl/crypto_rf_pkg.sv
`timescale 1ns/1ps
// Package: shared codes, tag bit positions and permission helpers for the
// crypto register file. Assumes a 5-bit tag and a 2-bit mode input.
package crypto_rf_pkg;

    localparam int TAG_W = 5;

    // Tag bit positions (decoded by the access checker)
    localparam int TB_KEY_LO = 0;
    localparam int TB_KEY_HI = 1;
    localparam int TB_RD_LO  = 2;
    localparam int TB_RD_HI  = 3;
    localparam int TB_WR_LO  = 4;

    localparam logic [1:0] MODE_HIGH = 2'd2;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_MOVE  = 3'd2,
        OP_XOR   = 3'd3,
        OP_RAND  = 3'd4,
        OP_CHMOD = 3'd5
    } rf_op_e;

    // True when the code names a state-changing command
    function automatic logic op_is_active(input logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd5);
    endfunction

    // Read permission for a tag in the given mode class
    function automatic logic tag_can_read(input logic [TAG_W-1:0] t, input logic hi);
        return hi ? t[TB_RD_HI] : t[TB_RD_LO];
    endfunction

    // Key-use permission for a tag in the given mode class
    function automatic logic tag_can_key(input logic [TAG_W-1:0] t, input logic hi);
        return hi ? t[TB_KEY_HI] : t[TB_KEY_LO];
    endfunction

    // Write permission: unconditional in the high mode
    function automatic logic tag_can_write(input logic [TAG_W-1:0] t, input logic hi);
        return hi | t[TB_WR_LO];
    endfunction

endpackage

// File: rtl/crf_access_check.sv
`timescale 1ns/1ps
// Module: crf_access_check
// Decides, from the current tags and mode, whether this cycle's command,
// read request and key request are granted or denied. Purely combinational.
// Assumes indices are in range (NREG a power of two).
module crf_access_check
    import crypto_rf_pkg::*;
#(
    parameter int NREG = 8,
    parameter int IDXW = 3
) (
    input  logic [TAG_W-1:0] tag_q [NREG],
    input  logic [1:0]       mode,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDXW-1:0]  cmd_dst,
    input  logic             rd_req,
    input  logic [IDXW-1:0]  rd_idx,
    input  logic             key_req,
    input  logic [IDXW-1:0]  key_idx,
    output logic             cmd_go,
    output logic             cmd_deny,
    output logic             rd_go,
    output logic             rd_deny,
    output logic             key_go,
    output logic             key_deny
);

    logic hi;
    logic cmd_act;
    logic wr_ok;
    logic rd_ok;
    logic key_ok;

    assign hi = (mode == MODE_HIGH);

    // Evaluate each access against the tag of the register it touches
    always_comb begin
        cmd_act  = cmd_valid && op_is_active(cmd_op);
        wr_ok    = tag_can_write(tag_q[cmd_dst], hi);
        rd_ok    = tag_can_read(tag_q[rd_idx], hi);
        key_ok   = tag_can_key(tag_q[key_idx], hi);
        cmd_go   = cmd_act && wr_ok;
        cmd_deny = cmd_act && !wr_ok;
        rd_go    = rd_req && rd_ok;
        rd_deny  = rd_req && !rd_ok;
        key_go   = key_req && key_ok;
        key_deny = key_req && !key_ok;
    end

endmodule

// File: rtl/crf_op_unit.sv
`timescale 1ns/1ps
// Module: crf_op_unit
// Forms the new data word and tag for the destination of a command, and
// says which of the two fields the command updates. Tags follow data on
// move (copied) and xor (AND of both sources). Combinational.
module crf_op_unit
    import crypto_rf_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 128,
    parameter int IDXW = 3
) (
    input  logic [DW-1:0]    data_q [NREG],
    input  logic [TAG_W-1:0] tag_q  [NREG],
    input  logic [2:0]       cmd_op,
    input  logic [IDXW-1:0]  cmd_dst,
    input  logic [IDXW-1:0]  cmd_src_a,
    input  logic [IDXW-1:0]  cmd_src_b,
    input  logic [TAG_W-1:0] cmd_imm,
    input  logic [DW-1:0]    cmd_wdata,
    input  logic [DW-1:0]    rnd_data,
    output logic             upd_data,
    output logic             upd_tag,
    output logic [DW-1:0]    new_data,
    output logic [TAG_W-1:0] new_tag
);

    // Select the result and the fields to update per command code
    always_comb begin
        upd_data = 1'b0;
        upd_tag  = 1'b0;
        new_data = data_q[cmd_dst];
        new_tag  = tag_q[cmd_dst];
        case (cmd_op)
            OP_LOAD: begin
                upd_data = 1'b1;
                new_data = cmd_wdata;
            end
            OP_MOVE: begin
                upd_data = 1'b1;
                upd_tag  = 1'b1;
                new_data = data_q[cmd_src_a];
                new_tag  = tag_q[cmd_src_a];
            end
            OP_XOR: begin
                upd_data = 1'b1;
                upd_tag  = 1'b1;
                new_data = data_q[cmd_src_a] ^ data_q[cmd_src_b];
                new_tag  = tag_q[cmd_src_a] & tag_q[cmd_src_b];
            end
            OP_RAND: begin
                upd_data = 1'b1;
                new_data = rnd_data;
            end
            OP_CHMOD: begin
                upd_tag  = 1'b1;
                new_tag  = cmd_imm;
            end
            default: begin
                upd_data = 1'b0;
                upd_tag  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/crf_reg_array.sv
`timescale 1ns/1ps
// Module: crf_reg_array
// Storage for NREG data words and their tags. One entry is written per
// cycle when wr_en is set; data and tag have separate enables. Reset puts
// zero in every word and all ones in every tag.
module crf_reg_array
    import crypto_rf_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 128,
    parameter int IDXW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic             upd_data,
    input  logic             upd_tag,
    input  logic [DW-1:0]    new_data,
    input  logic [TAG_W-1:0] new_tag,
    output logic [DW-1:0]    data_q [NREG],
    output logic [TAG_W-1:0] tag_q  [NREG]
);

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == IDXW'(g));

        // Hold one register and its tag; update the selected fields on a hit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g] <= '0;
                tag_q[g]  <= '1;
            end else if (hit) begin
                if (upd_data) data_q[g] <= new_data;
                if (upd_tag)  tag_q[g]  <= new_tag;
            end
        end
    end

endmodule

// File: rtl/crf_out_stage.sv
`timescale 1ns/1ps
// Module: crf_out_stage
// Registers the read and key responses and the fault pulse. Outputs are
// zero unless granted. Reads the pre-update state, so a command in the
// same cycle is not yet visible.
module crf_out_stage
    import crypto_rf_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 128,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   data_q [NREG],
    input  logic            rd_go,
    input  logic [IDXW-1:0] rd_idx,
    input  logic            key_go,
    input  logic [IDXW-1:0] key_idx,
    input  logic            any_deny,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            key_valid,
    output logic [DW-1:0]   key_data,
    output logic            fault
);

    // Capture the granted responses and the fault flag for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            key_valid <= 1'b0;
            key_data  <= '0;
            fault     <= 1'b0;
        end else begin
            rd_valid  <= rd_go;
            rd_data   <= rd_go ? data_q[rd_idx] : '0;
            key_valid <= key_go;
            key_data  <= key_go ? data_q[key_idx] : '0;
            fault     <= any_deny;
        end
    end

endmodule

// File: rtl/crypto_regfile.sv
`timescale 1ns/1ps
// Module: crypto_regfile (top)
// Tagged crypto register file: commands move, combine, fill or re-tag
// registers; read and key requests are checked against each register's
// tag in the current mode. Denied accesses pulse fault and change nothing.
module crypto_regfile
    import crypto_rf_pkg::*;
#(
    parameter  int NREG = 8,
    parameter  int DW   = 128,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDXW-1:0]  cmd_dst,
    input  logic [IDXW-1:0]  cmd_src_a,
    input  logic [IDXW-1:0]  cmd_src_b,
    input  logic [TAG_W-1:0] cmd_imm,
    input  logic [DW-1:0]    cmd_wdata,
    input  logic [DW-1:0]    rnd_data,
    input  logic             rd_req,
    input  logic [IDXW-1:0]  rd_idx,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    input  logic             key_req,
    input  logic [IDXW-1:0]  key_idx,
    output logic             key_valid,
    output logic [DW-1:0]    key_data,
    output logic             fault
);

    logic [DW-1:0]         data_q [NREG];
    logic [TAG_W-1:0]      tag_q  [NREG];
    logic [NREG*TAG_W-1:0] tag_flat;
    logic                  cmd_go, cmd_deny, rd_go, rd_deny, key_go, key_deny;
    logic                  upd_data, upd_tag;
    logic [DW-1:0]         new_data;
    logic [TAG_W-1:0]      new_tag;

    // Flattened view of all tags for the bound checker
    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign tag_flat[g*TAG_W +: TAG_W] = tag_q[g];
    end

    crf_access_check #(.NREG(NREG), .IDXW(IDXW)) u_check (
        .tag_q     (tag_q),
        .mode      (mode),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_dst   (cmd_dst),
        .rd_req    (rd_req),
        .rd_idx    (rd_idx),
        .key_req   (key_req),
        .key_idx   (key_idx),
        .cmd_go    (cmd_go),
        .cmd_deny  (cmd_deny),
        .rd_go     (rd_go),
        .rd_deny   (rd_deny),
        .key_go    (key_go),
        .key_deny  (key_deny)
    );

    crf_op_unit #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_op (
        .data_q    (data_q),
        .tag_q     (tag_q),
        .cmd_op    (cmd_op),
        .cmd_dst   (cmd_dst),
        .cmd_src_a (cmd_src_a),
        .cmd_src_b (cmd_src_b),
        .cmd_imm   (cmd_imm),
        .cmd_wdata (cmd_wdata),
        .rnd_data  (rnd_data),
        .upd_data  (upd_data),
        .upd_tag   (upd_tag),
        .new_data  (new_data),
        .new_tag   (new_tag)
    );

    crf_reg_array #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd_go),
        .wr_idx   (cmd_dst),
        .upd_data (upd_data),
        .upd_tag  (upd_tag),
        .new_data (new_data),
        .new_tag  (new_tag),
        .data_q   (data_q),
        .tag_q    (tag_q)
    );

    crf_out_stage #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_q    (data_q),
        .rd_go     (rd_go),
        .rd_idx    (rd_idx),
        .key_go    (key_go),
        .key_idx   (key_idx),
        .any_deny  (cmd_deny | rd_deny | key_deny),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .key_valid (key_valid),
        .key_data  (key_data),
        .fault     (fault)
    );

endmodule

// File: rtl/crypto_regfile_chk.sv
`timescale 1ns/1ps
// Module: crypto_regfile_chk
// Property checker bound to crypto_regfile. Relates port activity and the
// stored tags over time. Assumes synchronous active-low reset.
module crypto_regfile_chk #(
    parameter int NREG = 8,
    parameter int DW   = 128,
    parameter int IDXW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [IDXW-1:0]   cmd_dst,
    input logic [IDXW-1:0]   cmd_src_a,
    input logic [4:0]        cmd_imm,
    input logic              rd_req,
    input logic              key_req,
    input logic              rd_valid,
    input logic [DW-1:0]     rd_data,
    input logic              key_valid,
    input logic [DW-1:0]     key_data,
    input logic              fault,
    input logic [NREG*5-1:0] tag_flat
);

    logic            seen;
    logic            prev_chmod_hi, prev_move_hi;
    logic [IDXW-1:0] prev_dst;
    logic [4:0]      prev_imm, prev_src_tag;

    // Record the last high-mode re-tag or move, and the first active cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen          <= 1'b0;
            prev_chmod_hi <= 1'b0;
            prev_move_hi  <= 1'b0;
            prev_dst      <= '0;
            prev_imm      <= '0;
            prev_src_tag  <= '0;
        end else begin
            seen          <= 1'b1;
            prev_chmod_hi <= cmd_valid && (cmd_op == 3'd5) && (mode == 2'd2);
            prev_move_hi  <= cmd_valid && (cmd_op == 3'd2) && (mode == 2'd2);
            prev_dst      <= cmd_dst;
            prev_imm      <= cmd_imm;
            prev_src_tag  <= tag_flat[cmd_src_a*5 +: 5];
        end
    end

    p_reset_tags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (tag_flat == '1) && !fault && !rd_valid && !key_valid);

    p_rd_zero_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    p_rd_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    p_key_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> (key_data == '0));

    p_key_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> $past(key_req));

    p_move_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prev_move_hi |-> (tag_flat[prev_dst*5 +: 5] == prev_src_tag));

    p_chmod_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prev_chmod_hi |-> (tag_flat[prev_dst*5 +: 5] == prev_imm));

    p_fault_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && seen) |-> $past(cmd_valid || rd_req || key_req));

endmodule

bind crypto_regfile crypto_regfile_chk #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_dst   (cmd_dst),
    .cmd_src_a (cmd_src_a),
    .cmd_imm   (cmd_imm),
    .rd_req    (rd_req),
    .key_req   (key_req),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .key_valid (key_valid),
    .key_data  (key_data),
    .fault     (fault),
    .tag_flat  (tag_flat)
);

// File: tb/crypto_regfile_tb.sv
`timescale 1ns/1ps
// Bench for crypto_regfile: directed corner cases, then seeded random
// traffic, all compared against a shadow model kept in the bench.
module crypto_regfile_tb;

    localparam int DW = 128;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = '0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [2:0]    cmd_dst = '0, cmd_src_a = '0, cmd_src_b = '0;
    logic [4:0]    cmd_imm = '0;
    logic [DW-1:0] cmd_wdata = '0, rnd_data = '0;
    logic          rd_req = 1'b0, key_req = 1'b0;
    logic [2:0]    rd_idx = '0, key_idx = '0;
    logic          rd_valid, key_valid, fault;
    logic [DW-1:0] rd_data, key_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [DW-1:0] m_data [NR];
    logic [4:0]    m_tag  [NR];

    always #2 clk = ~clk;

    crypto_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a),
        .cmd_src_b(cmd_src_b), .cmd_imm(cmd_imm), .cmd_wdata(cmd_wdata),
        .rnd_data(rnd_data), .rd_req(rd_req), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data), .key_req(key_req),
        .key_idx(key_idx), .key_valid(key_valid), .key_data(key_data),
        .fault(fault)
    );

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic may_read(input logic [4:0] t, input logic [1:0] m);
        return (m == 2'd2) ? t[3] : t[2];
    endfunction

    function automatic logic may_key(input logic [4:0] t, input logic [1:0] m);
        return (m == 2'd2) ? t[1] : t[0];
    endfunction

    function automatic logic may_write(input logic [4:0] t, input logic [1:0] m);
        return (m == 2'd2) || t[4];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the negedge, predict, compare one edge later
    task automatic step(input string tag, input logic [1:0] m,
                        input logic cv, input logic [2:0] op,
                        input logic [2:0] dst, input logic [2:0] sa,
                        input logic [2:0] sb, input logic [4:0] imm,
                        input logic [DW-1:0] wd, input logic [DW-1:0] rn,
                        input logic rq, input logic [2:0] ri,
                        input logic kq, input logic [2:0] ki);
        logic          e_rv, e_kv, e_f, act, ok;
        logic [DW-1:0] e_rd, e_kd;
        mode = m; cmd_valid = cv; cmd_op = op; cmd_dst = dst;
        cmd_src_a = sa; cmd_src_b = sb; cmd_imm = imm; cmd_wdata = wd;
        rnd_data = rn; rd_req = rq; rd_idx = ri; key_req = kq; key_idx = ki;
        e_rv = rq && may_read(m_tag[ri], m);
        e_rd = e_rv ? m_data[ri] : '0;
        e_kv = kq && may_key(m_tag[ki], m);
        e_kd = e_kv ? m_data[ki] : '0;
        act  = cv && (op >= 3'd1) && (op <= 3'd5);
        ok   = may_write(m_tag[dst], m);
        e_f  = (act && !ok) || (rq && !e_rv) || (kq && !e_kv);
        if (act && ok) begin
            case (op)
                3'd1: m_data[dst] = wd;
                3'd2: begin m_data[dst] = m_data[sa]; m_tag[dst] = m_tag[sa]; end
                3'd3: begin
                    logic [DW-1:0] x;
                    logic [4:0]    t;
                    x = m_data[sa] ^ m_data[sb];
                    t = m_tag[sa] & m_tag[sb];
                    m_data[dst] = x; m_tag[dst] = t;
                end
                3'd4: m_data[dst] = rn;
                default: m_tag[dst] = imm;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "rd_valid", DW'(rd_valid), DW'(e_rv));
        check(tag, "rd_data", rd_data, e_rd);
        check(tag, "key_valid", DW'(key_valid), DW'(e_kv));
        check(tag, "key_data", key_data, e_kd);
        check(tag, "fault", DW'(fault), DW'(e_f));
    endtask

    task automatic rd(input string tag, input logic [1:0] m, input logic [2:0] i);
        step(tag, m, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 5'd0, '0, '0, 1'b1, i, 1'b1, i);
    endtask

    task automatic cmd(input string tag, input logic [1:0] m, input logic [2:0] op,
                       input logic [2:0] dst, input logic [2:0] sa,
                       input logic [2:0] sb, input logic [4:0] imm,
                       input logic [DW-1:0] wd);
        step(tag, m, 1'b1, op, dst, sa, sb, imm, wd, rnd_word(), 1'b0, 3'd0, 1'b0, 3'd0);
    endtask

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) begin m_data[i] = '0; m_tag[i] = 5'h1F; end
        repeat (3) @(negedge clk);
        // R1: outputs idle while reset is held
        check("R1", "fault in reset", DW'(fault), '0);
        check("R1", "rd_valid in reset", DW'(rd_valid), '0);
        rst_n = 1'b1;
        // R1: every register zero and fully permitted after reset
        for (int i = 0; i < NR; i++) rd("R1", 2'd0, 3'(i));
        // R5: lower-mode load allowed by reset tag bit 4
        v = rnd_word();
        cmd("R5", 2'd1, 3'd1, 3'd0, 3'd0, 3'd0, 5'd0, v);
        rd("R5", 2'd0, 3'd0);
        // R9 / R2: tag 5'b01010 = key high, read high only
        cmd("R9", 2'd2, 3'd5, 3'd0, 3'd0, 3'd0, 5'b01010, '0);
        rd("R2", 2'd3, 3'd0);
        rd("R2", 2'd2, 3'd0);
        rd("R9", 2'd0, 3'd0);
        // R10: lower-mode write to r0 denied (bit 4 clear), data kept
        cmd("R10", 2'd0, 3'd1, 3'd0, 3'd0, 3'd0, 5'd0, rnd_word());
        cmd("R10", 2'd1, 3'd5, 3'd0, 3'd0, 3'd0, 5'h1F, '0);
        rd("R10", 2'd2, 3'd0);
        // R10: high mode writes regardless of bit 4
        cmd("R10", 2'd2, 3'd4, 3'd0, 3'd0, 3'd0, 5'd0, '0);
        rd("R10", 2'd2, 3'd0);
        // R10: codes 6 and 7 are inert
        cmd("R10", 2'd0, 3'd6, 3'd0, 3'd0, 3'd0, 5'd0, rnd_word());
        cmd("R10", 2'd0, 3'd7, 3'd0, 3'd0, 3'd0, 5'd0, rnd_word());
        rd("R10", 2'd2, 3'd0);
        // R6: move carries the read-protected tag into r2
        cmd("R6", 2'd0, 3'd2, 3'd2, 3'd0, 3'd0, 5'd0, '0);
        rd("R6", 2'd0, 3'd2);
        rd("R6", 2'd2, 3'd2);
        // R7: xor with AND of tags, then self-clear
        cmd("R7", 2'd2, 3'd1, 3'd3, 3'd0, 3'd0, 5'd0, rnd_word());
        cmd("R7", 2'd2, 3'd3, 3'd4, 3'd2, 3'd3, 5'd0, '0);
        rd("R7", 2'd2, 3'd4);
        rd("R7", 2'd0, 3'd4);
        cmd("R7", 2'd2, 3'd3, 3'd3, 3'd3, 3'd3, 5'd0, '0);
        rd("R7", 2'd1, 3'd3);
        // R8: random fill takes rnd_data
        cmd("R8", 2'd1, 3'd4, 3'd5, 3'd0, 3'd0, 5'd0, '0);
        rd("R8", 2'd0, 3'd5);
        // R11: read in the same cycle as a load sees the old word
        step("R11", 2'd2, 1'b1, 3'd1, 3'd6, 3'd0, 3'd0, 5'd0, rnd_word(), '0,
             1'b1, 3'd6, 1'b1, 3'd6);
        rd("R11", 2'd2, 3'd6);
        // R12: denied read pulses fault once, idle cycle clears it
        rd("R12", 2'd0, 3'd0);
        step("R12", 2'd0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 5'd0, '0, '0,
             1'b0, 3'd0, 1'b0, 3'd0);
        // R3 R4 R11: seeded random traffic against the shadow model
        for (int n = 0; n < 1500; n++) begin
            logic [2:0] op;
            logic [4:0] imm;
            op  = 3'($urandom_range(0, 7));
            imm = 5'($urandom) | ((($urandom % 4) != 0) ? 5'h1C : 5'h00);
            step((n % 2) ? "R3" : "R4", 2'($urandom), ($urandom % 4) != 0, op,
                 3'($urandom), 3'($urandom), 3'($urandom), imm,
                 rnd_word(), rnd_word(), 1'($urandom), 3'($urandom),
                 1'($urandom), 3'($urandom));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule